// File: doc/BRIEF.md
# Reciprocal Seven-Bit Estimator

This unit returns an approximation of 1/x for a binary floating-point operand. The approximation is good to about seven bits. The operand can be half, single or double precision and arrives right-aligned on a 64-bit bus, with a two-bit format select. The result and a five-bit exception flag vector are registered once, so they appear one clock after the operand is presented.

The estimate comes from a 128-entry table indexed by the top seven fraction bits of the normalized operand. The output exponent is 2·bias − 1 minus the normalized input exponent. Subnormal operands are normalized before the lookup. If the computed exponent is 0 or −1, the result is denormalized by shifting the significand. Operands that are too tiny saturate according to the rounding-mode input. Zeros, infinities and NaNs take dedicated paths.

Top module: `recip7_est`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high after that edge and `result`/`flags` hold the answer for that operand. When `inValid` is low at an edge, `outValid` is low after it and `result` keeps its value. Reset clears `outValid`, `result` and `flags`.
- R2: `fmt` 0 selects half precision (operand and result in bits 15:0), 1 selects single (bits 31:0), and 2 or 3 select double. Operand bits above the selected width are ignored, and result bits above it are zero.
- R3: An infinity input returns a zero of the same sign with no flags set. The flag layout is bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R4: A zero input returns an infinity of the same sign, with only the divide-by-zero flag (bit 3) set.
- R5: A NaN whose fraction MSB is 0 (signalling) returns the canonical NaN with only the invalid flag (bit 4) set. A NaN whose fraction MSB is 1 returns the canonical NaN with no flags. The canonical NaN has sign 0, an all-ones exponent, and a fraction holding only its MSB.
- R6: A normal input x returns sign(x), exponent 2·bias − 1 − exp(x), and a fraction whose top seven bits are T[i] with zeros below, with no flags. Here i is the top seven fraction bits and T[i] = round(65536/(257+2i)) − 128, so T[0]=127 and T[127]=0.
- R7: When the computed exponent is 0, the output exponent is 0 and the fraction is 1 followed by the estimate fraction shifted right by one.
- R8: When the computed exponent is −1, the output exponent is 0 and the fraction is the bits 01 followed by the estimate fraction shifted right by two.
- R9: A subnormal input with at most one leading zero in its fraction is normalized first. The exponent becomes −lz, and the fraction is shifted left by lz+1. The result then follows R6 to R8.
- R10: A subnormal input with two or more leading fraction zeros sets overflow and inexact (bits 2 and 0). It returns the largest finite value of its sign when `rm` is 001, when `rm` is 010 with a positive sign, or when `rm` is 011 with a negative sign. Otherwise it returns an infinity of its sign.
- R11: `rm` has no effect on any input other than those covered by R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Format select: 0 half, 1 single, 2/3 double |
| rm | input | 3 | Rounding mode, used only for tiny-subnormal saturation |
| opIn | input | 64 | Operand, right-aligned |
| outValid | output | 1 | Result present |
| result | output | 64 | Estimate, right-aligned, upper bits zero |
| flags | output | 5 | NV, DZ, OF, UF, NX (bit 4 down to bit 0) |

## Verification
The assertions assume that `fmt` is stable whenever `inValid` is high. They also assume that a result flagged divide-by-zero or invalid is judged against the format of the operand that produced it. The design registers that format next to the result. The stimulus drives every operand, format and mode together on a falling edge and holds them until the following falling edge, so each registered triple is coherent. The sweep covers every table index, the exponent boundaries around 0 and −1, subnormals with zero, one, two and many leading zeros, and all eight rounding modes in each format. Expected values come from an arithmetic model in the bench.

// File: rtl/recip7_pkg.sv
package recip7_pkg;

  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int IDX_W  = 7;
  localparam int TBL_N  = 1 << IDX_W;
  localparam int LZ_W   = $clog2(FRAC_W + 1);
  localparam int SEXP_W = EXP_W + 2;
  localparam int FLG_W  = 5;

  localparam int FLG_NV = 4;
  localparam int FLG_DZ = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  typedef enum logic [2:0] {
    K_EST, K_ZERO, K_INF, K_NAN, K_MAXFIN
  } resKind_e;

  typedef struct packed {
    logic sign;
    logic expZero;
    logic expMax;
    logic fracZero;
    logic quietBit;
    logic lowLead;
  } opClass_t;

  typedef struct packed {
    resKind_e          kind;
    logic              subIn;
    logic [FLG_W-1:0]  flags;
  } ctlStrobe_t;

  // T[i] = round(2^(2*IDX_W+2) / (2^(IDX_W+1) + 1 + 2i)) - 2^IDX_W
  function automatic logic [TBL_N*IDX_W-1:0] mkTable();
    logic [TBL_N*IDX_W-1:0] t;
    t = '0;
    for (int i = 0; i < TBL_N; i++) begin
      int num;
      int den;
      int q;
      num = 1 << (2 * IDX_W + 2);
      den = (1 << (IDX_W + 1)) + 1 + 2 * i;
      q   = (2 * num + den) / (2 * den) - (1 << IDX_W);
      t[i*IDX_W +: IDX_W] = q[IDX_W-1:0];
    end
    return t;
  endfunction

  function automatic logic isInfVal(input logic [1:0] f, input logic [63:0] v);
    case (f)
      2'd0:    return v[14:10] == 5'h1f && v[9:0] == '0;
      2'd1:    return v[30:23] == 8'hff && v[22:0] == '0;
      default: return v[62:52] == 11'h7ff && v[51:0] == '0;
    endcase
  endfunction

  function automatic logic isCanonNan(input logic [1:0] f, input logic [63:0] v);
    case (f)
      2'd0:    return v == 64'h0000_0000_0000_7e00;
      2'd1:    return v == 64'h0000_0000_7fc0_0000;
      default: return v == 64'h7ff8_0000_0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/recip7_ctrl.sv
module recip7_ctrl
  import recip7_pkg::*;
(
  input  opClass_t   opClass,
  input  logic [2:0] rm,
  output ctlStrobe_t strobe
);

  logic toMaxFin;

  always_comb begin
    toMaxFin = (rm == 3'b001) ||
               (rm == 3'b010 && !opClass.sign) ||
               (rm == 3'b011 && opClass.sign);
  end

  always_comb begin
    strobe       = '0;
    strobe.kind  = K_EST;
    if (opClass.expMax) begin
      if (opClass.fracZero) begin
        strobe.kind = K_ZERO;
      end else begin
        strobe.kind = K_NAN;
        strobe.flags[FLG_NV] = !opClass.quietBit;
      end
    end else if (opClass.expZero) begin
      if (opClass.fracZero) begin
        strobe.kind = K_INF;
        strobe.flags[FLG_DZ] = 1'b1;
      end else if (opClass.lowLead) begin
        strobe.kind = toMaxFin ? K_MAXFIN : K_INF;
        strobe.flags[FLG_OF] = 1'b1;
        strobe.flags[FLG_NX] = 1'b1;
      end else begin
        strobe.subIn = 1'b1;
      end
    end
  end

endmodule

// File: rtl/recip7_datapath.sv
module recip7_datapath
  import recip7_pkg::*;
(
  input  logic [1:0]  fmt,
  input  logic [63:0] opIn,
  input  ctlStrobe_t  strobe,
  output opClass_t    opClass,
  output logic [63:0] estOut
);

  localparam logic [TBL_N*IDX_W-1:0] RECIP_TBL = mkTable();

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [EXP_W-1:0]  expMask;
  logic [FRAC_W-1:0] frac;
  logic [SEXP_W-1:0] bias;
  logic [LZ_W-1:0]   lzc;
  logic              lzFound;
  logic [LZ_W:0]     shamt;
  logic [SEXP_W-1:0] normExp;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  tblVal;
  logic [SEXP_W-1:0] midExp;
  logic [EXP_W-1:0]  estExp;
  logic [FRAC_W-1:0] estFrac;
  logic              oSign;
  logic [EXP_W-1:0]  oExp;
  logic [FRAC_W-1:0] oFrac;

  // unpack: fraction left-aligned so every format shares one datapath
  always_comb begin
    case (fmt)
      2'd0: begin
        sign = opIn[15]; expo = {6'b0, opIn[14:10]};
        frac = {opIn[9:0], 42'b0}; expMask = 11'h1f; bias = 13'd15;
      end
      2'd1: begin
        sign = opIn[31]; expo = {3'b0, opIn[30:23]};
        frac = {opIn[22:0], 29'b0}; expMask = 11'hff; bias = 13'd127;
      end
      default: begin
        sign = opIn[63]; expo = opIn[62:52];
        frac = opIn[51:0]; expMask = 11'h7ff; bias = 13'd1023;
      end
    endcase
  end

  always_comb begin
    opClass.sign     = sign;
    opClass.expZero  = expo == '0;
    opClass.expMax   = expo == expMask;
    opClass.fracZero = frac == '0;
    opClass.quietBit = frac[FRAC_W-1];
    opClass.lowLead  = frac[FRAC_W-1 -: 2] == 2'b00;
  end

  always_comb begin
    lzc     = '0;
    lzFound = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!lzFound && frac[i]) begin
        lzc     = LZ_W'(FRAC_W - 1 - i);
        lzFound = 1'b1;
      end
    end
  end

  always_comb begin
    shamt   = {1'b0, lzc} + 1'b1;
    normExp = strobe.subIn ? -SEXP_W'(lzc) : SEXP_W'(expo);
    idx     = strobe.subIn ? IDX_W'((frac << shamt) >> (FRAC_W - IDX_W))
                           : frac[FRAC_W-1 -: IDX_W];
    tblVal  = RECIP_TBL[idx*IDX_W +: IDX_W];
    midExp  = (bias << 1) - SEXP_W'(1) - normExp;
  end

  always_comb begin
    if (midExp == '0) begin
      estExp  = '0;
      estFrac = {1'b1, tblVal, {(FRAC_W-IDX_W-1){1'b0}}};
    end else if (midExp == '1) begin
      estExp  = '0;
      estFrac = {2'b01, tblVal, {(FRAC_W-IDX_W-2){1'b0}}};
    end else begin
      estExp  = midExp[EXP_W-1:0];
      estFrac = {tblVal, {(FRAC_W-IDX_W){1'b0}}};
    end
  end

  always_comb begin
    oSign = sign;
    case (strobe.kind)
      K_ZERO:   begin oExp = '0;               oFrac = '0; end
      K_INF:    begin oExp = expMask;          oFrac = '0; end
      K_NAN:    begin oSign = 1'b0; oExp = expMask;
                      oFrac = {1'b1, {(FRAC_W-1){1'b0}}}; end
      K_MAXFIN: begin oExp = expMask - 1'b1;   oFrac = '1; end
      default:  begin oExp = estExp;           oFrac = estFrac; end
    endcase
  end

  always_comb begin
    case (fmt)
      2'd0:    estOut = {48'b0, oSign, oExp[4:0], oFrac[51:42]};
      2'd1:    estOut = {32'b0, oSign, oExp[7:0], oFrac[51:29]};
      default: estOut = {oSign, oExp, oFrac};
    endcase
  end

endmodule

// File: rtl/recip7_est.sv
module recip7_est
  import recip7_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       fmt,
  input  logic [2:0]       rm,
  input  logic [63:0]      opIn,
  output logic             outValid,
  output logic [63:0]      result,
  output logic [FLG_W-1:0] flags
);

  opClass_t    opClass;
  ctlStrobe_t  strobe;
  logic [63:0] estOut;
  logic [1:0]  fmtQ;

  recip7_ctrl u_ctrl (
    .opClass (opClass),
    .rm      (rm),
    .strobe  (strobe)
  );

  recip7_datapath u_dp (
    .fmt     (fmt),
    .opIn    (opIn),
    .strobe  (strobe),
    .opClass (opClass),
    .estOut  (estOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flags    <= '0;
      fmtQ     <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result <= estOut;
        flags  <= strobe.flags;
        fmtQ   <= fmt;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result)));

  // R2
  half_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtQ == 2'd0) |-> result[63:16] == '0);

  // R4
  dz_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags[FLG_DZ]) |-> isInfVal(fmtQ, result));

  // R5
  nv_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags[FLG_NV]) |-> isCanonNan(fmtQ, result));

  // R10
  of_nx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags[FLG_OF]) |-> (flags[FLG_NX] && !flags[FLG_UF]));

endmodule

// File: tb/tb_recip7_est.sv
module tb_recip7_est;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  fmt;
  logic [2:0]  rm;
  logic [63:0] opIn;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  flags;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  recip7_est dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmt(fmt), .rm(rm),
    .opIn(opIn), .outValid(outValid), .result(result), .flags(flags)
  );

  function automatic int tblRef(input int i);
    real r;
    r = 256.0 * 128.0 / (128.0 + i + 0.5);
    return $rtoi(r + 0.5) - 128;
  endfunction

  // returns {flags, result}
  function automatic logic [68:0] model(input int f, input logic [2:0] rmv,
                                        input logic [63:0] v);
    int e, s, bias, ex, lz, nexp, mexp, idx;
    logic [63:0] fr, nfr, mfr, mask, emax, sgn, res;
    logic [4:0] fl;
    e = (f == 0) ? 5 : (f == 1) ? 8 : 11;
    s = (f == 0) ? 10 : (f == 1) ? 23 : 52;
    bias = (1 << (e - 1)) - 1;
    mask = (64'd1 << s) - 1;
    emax = (64'd1 << e) - 1;
    sgn  = 64'(v[e + s]) << (e + s);
    ex   = int'((v >> s) & emax);
    fr   = v & mask;
    fl   = 5'b0;
    if (ex == int'(emax)) begin
      if (fr == 0) res = sgn;
      else begin
        res = (emax << s) | (64'd1 << (s - 1));
        if (fr[s-1] == 1'b0) fl = 5'b10000;
      end
    end else if (ex == 0 && fr == 0) begin
      res = sgn | (emax << s); fl = 5'b01000;
    end else begin
      lz = 0;
      if (ex == 0) while (fr[s-1-lz] == 1'b0) lz++;
      if (ex == 0 && lz > 1) begin
        fl = 5'b00101;
        if (rmv == 3'b001 || (rmv == 3'b010 && sgn == 0) || (rmv == 3'b011 && sgn != 0))
          res = sgn | ((emax - 1) << s) | mask;
        else
          res = sgn | (emax << s);
      end else begin
        if (ex == 0) begin nexp = -lz; nfr = (fr << (1 + lz)) & mask; end
        else begin nexp = ex; nfr = fr; end
        idx  = int'(nfr >> (s - 7));
        mfr  = 64'(tblRef(idx)) << (s - 7);
        mexp = 2 * bias - 1 - nexp;
        if (mexp == 0) res = sgn | (mfr >> 1) | (64'd1 << (s - 1));
        else if (mexp == -1) res = sgn | (mfr >> 2) | (64'd1 << (s - 2));
        else res = sgn | (64'(mexp) << s) | mfr;
      end
    end
    return {fl, res};
  endfunction

  task automatic check(input string tag, input logic [68:0] got, input logic [68:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic runOne(input string tag, input int f, input logic [2:0] rmv,
                        input logic [63:0] v);
    logic [68:0] exp;
    int wid;
    wid = (f == 0) ? 16 : (f == 1) ? 32 : 64;
    // R2: garbage above the operand width must be ignored
    if (wid < 64) v = v | (64'hA5C3_96F0_5A3C_690F << wid);
    exp = model((f == 3) ? 2 : f, rmv, v);
    @(negedge clk);
    inValid = 1'b1; fmt = 2'(f); rm = rmv; opIn = v;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, {flags, result}, exp);
    if (!outValid) begin
      checks++; fails++;
      $display("FAIL R1 outValid got 0 exp 1");
    end
  endtask

  function automatic logic [63:0] mk(input int f, input int sg, input longint ex,
                                     input logic [63:0] fr);
    int e, s;
    e = (f == 0) ? 5 : (f == 1) ? 8 : 11;
    s = (f == 0) ? 10 : (f == 1) ? 23 : 52;
    return (64'(sg) << (e + s)) | (64'(ex) << s) | (fr & ((64'd1 << s) - 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; fmt = '0; rm = '0; opIn = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {4'b0, outValid, result}, 69'd0);
    rstN = 1'b1;

    for (int f = 0; f < 4; f++) begin
      int e, s;
      longint emax, bias;
      logic [63:0] fm;
      e = (f == 0) ? 5 : (f == 1) ? 8 : 11;
      s = (f == 0) ? 10 : (f == 1) ? 23 : 52;
      emax = (longint'(1) << e) - 1;
      bias = (longint'(1) << (e - 1)) - 1;
      fm = (64'd1 << s) - 1;
      for (int sg = 0; sg < 2; sg++) begin
        runOne("R3 inf", f, 3'd0, mk(f, sg, emax, 0));
        runOne("R4 zero", f, 3'd2, mk(f, sg, 0, 0));
        runOne("R5 snan", f, 3'd0, mk(f, sg, emax, 64'd1));
        runOne("R5 qnan", f, 3'd0, mk(f, sg, emax, 64'd1 << (s - 1)));
        // R6 every table index
        for (int i = 0; i < 128; i++)
          runOne("R6 index", f, 3'd0, mk(f, sg, bias, (64'(i) << (s - 7)) | 64'h5));
        for (int k = 0; k < 4; k++) begin
          logic [63:0] fp;
          fp = (k == 0) ? 64'd0 : (k == 1) ? fm : (k == 2) ? (64'h1 << (s - 1)) : 64'h2d;
          runOne("R6 exp1", f, 3'd0, mk(f, sg, 1, fp));
          runOne("R6 exphi", f, 3'd0, mk(f, sg, 2 * bias - 2, fp));
          runOne("R7 mid0", f, 3'd0, mk(f, sg, 2 * bias - 1, fp));
          runOne("R8 midm1", f, 3'd0, mk(f, sg, 2 * bias, fp));
          runOne("R9 sub lz0", f, 3'd0, mk(f, sg, 0, fp | (64'd1 << (s - 1))));
          runOne("R9 sub lz1", f, 3'd0, mk(f, sg, 0, (fp >> 1) | (64'd1 << (s - 2))));
        end
        for (int r = 0; r < 8; r++) begin
          runOne("R10 lz2", f, 3'(r), mk(f, sg, 0, 64'd1 << (s - 3)));
          runOne("R10 min", f, 3'(r), mk(f, sg, 0, 64'd1));
          runOne("R11 rm", f, 3'(r), mk(f, sg, bias + 3, fm >> 2));
          runOne("R11 rmsub", f, 3'(r), mk(f, sg, 0, fm));
        end
      end
    end

    // R1 idle cycle: no valid, result held
    begin
      logic [63:0] held;
      held = result;
      @(negedge clk);
      check("R1 idle", {4'b0, outValid, result}, {5'b0, held});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule